// File: doc/BRIEF.md
# Programmable Scan-Line Timing Generator

This block steps through the horizontal layout of one composite video scan line, one pixel clock cycle at a time. Each segment of the line (sync tip, breezeway, colour burst, colour back porch, extended back porch, active video) has its own programmable length in cycles. A front porch fills whatever remains up to a programmable total line length. A line counter advances once per line and wraps after 525 or 625 lines, depending on a mode bit.

Software writes byte-wide registers through a simple write port. Every write lands in a pending copy. The whole pending set is moved into the working copy on the last cycle of a line, so each line is generated from a single consistent configuration. The outputs are level strobes for each segment, plus a pedestal-enable flag and a colour-system status bit for the stages further down the video path.

Top module: `vlt_line_timer`

## Requirements
- R1: After each line start, `sync_o` is high for exactly the programmed sync length (address 0) and low for the rest of the line.
- R2: `burst_o` is high only during the burst segment. That segment starts after sync plus breezeway (address 1) and lasts the burst length (address 2).
- R3: `active_o` is high for the active length. It starts after sync, breezeway, burst, colour back porch (address 3) and extended back porch. `blank_o` is its complement.
- R4: The 10-bit lengths take their low byte from addresses 4 (extended back porch), 5 (active), 6 (first half) and 7 (last half). Their two top bits come from address 8: bits 1:0 for the extended back porch, 3:2 for active, 5:4 for first half and 7:6 for last half.
- R5: A segment programmed to length zero takes no cycles, and its strobe stays low for the whole line.
- R6: The line lasts the 11-bit total length, with the low byte at address 9 and bits 10:8 at address 10 bits 2:0. A total of 0 acts as 1. `line_start_o` is high on the first cycle of each line. Segments running past the total are cut off.
- R7: `line_num_o` advances by one per line. It wraps to 0 after line 524 when address 11 bit 0 is clear, and after line 624 when that bit is set.
- R8: A write changes nothing in the current line. It takes effect from the next line start.
- R9: `pal_o` follows address 11 bit 1, taking effect at the next line start.
- R10: `pedestal_o` is high exactly when `active_o` is high and address 11 bit 2 is set.
- R11: `act_first_o` is high during the first N active cycles, where N is the first-half length. `act_last_o` is high during the last M active cycles, where M is the last-half length. Both are limited to the active window.
- R12: After reset the block is at line 0, position 0, with the sync tip starting. The configuration is then sync 4, breezeway 2, burst 4, colour back porch 2, extended back porch 0, active 40, halves 20 and 20, total 64, with all mode bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 to 11, others ignored) |
| wr_data | input | 8 | Register write data |
| sync_o | output | 1 | Sync tip strobe |
| burst_o | output | 1 | Burst gate |
| blank_o | output | 1 | Blanking (not active video) |
| active_o | output | 1 | Active video window |
| act_first_o | output | 1 | First-half part of active video |
| act_last_o | output | 1 | Last-half part of active video |
| line_start_o | output | 1 | First cycle of a line |
| pedestal_o | output | 1 | Setup pedestal enable |
| pal_o | output | 1 | Colour-system status (1 = PAL) |
| line_num_o | output | 10 | Current line number |

## Verification
All strobes are decoded from the registered position counter. They are therefore valid from the clock edge that moves the position, and the bench samples them on the following falling edge. A write is registered at one edge but only becomes visible after the edge that ends the current line. The bench's behavioural model applies the pending-to-working copy before the write at that same edge, so a write on a line's last cycle is expected one line later. Directed checks count falling edges from the observed `line_start_o` to reach a known position within the line before sampling.

// File: rtl/vlt_pkg.sv
// Shared widths, register addresses, configuration type and reset
// configuration for the scan-line timing generator.
package vlt_pkg;
    localparam int SHORT_W = 8;              // short segment length width
    localparam int LONG_W  = 10;             // long segment length width
    localparam int TOT_W   = 11;             // total line length width
    localparam int LINE_W  = 10;             // line counter width
    localparam int NSEG    = 6;              // segments before the front porch
    localparam int END_W   = TOT_W + 2;      // room for the sum of all segments
    localparam int ADDR_W  = 4;

    localparam logic [ADDR_W-1:0] A_SYNC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_BWAY  = 4'd1;
    localparam logic [ADDR_W-1:0] A_BURST = 4'd2;
    localparam logic [ADDR_W-1:0] A_CBP   = 4'd3;
    localparam logic [ADDR_W-1:0] A_XBP   = 4'd4;
    localparam logic [ADDR_W-1:0] A_ACT   = 4'd5;
    localparam logic [ADDR_W-1:0] A_FIRST = 4'd6;
    localparam logic [ADDR_W-1:0] A_LAST  = 4'd7;
    localparam logic [ADDR_W-1:0] A_MSB   = 4'd8;
    localparam logic [ADDR_W-1:0] A_TOTL  = 4'd9;
    localparam logic [ADDR_W-1:0] A_TOTH  = 4'd10;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd11;

    localparam int LINES_A = 525;
    localparam int LINES_B = 625;

    typedef struct packed {
        logic [SHORT_W-1:0] sync_len;
        logic [SHORT_W-1:0] bway_len;
        logic [SHORT_W-1:0] burst_len;
        logic [SHORT_W-1:0] cbp_len;
        logic [LONG_W-1:0]  xbp_len;
        logic [LONG_W-1:0]  act_len;
        logic [LONG_W-1:0]  first_len;
        logic [LONG_W-1:0]  last_len;
        logic [TOT_W-1:0]   total;
        logic               lines625;
        logic               pal;
        logic               setup;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        sync_len:  8'd4,  bway_len: 8'd2,   burst_len: 8'd4,  cbp_len: 8'd2,
        xbp_len:   10'd0, act_len:  10'd40, first_len: 10'd20, last_len: 10'd20,
        total:     11'd64, lines625: 1'b0,  pal: 1'b0,        setup: 1'b0
    };
endpackage

// File: rtl/vlt_cfg_regs.sv
// Register file with pending and working copies. Writes update the
// pending copy; the working copy is loaded from the pending copy only
// when `load` is high (last cycle of a line). Assumes one write per cycle.
module vlt_cfg_regs
    import vlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load,
    output cfg_t              cfg
);
    cfg_t pend_q;
    cfg_t work_q;

    // Capture register writes into the pending copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= CFG_RST;
        end else if (wr_en) begin
            case (wr_addr)
                A_SYNC:  pend_q.sync_len       <= wr_data;
                A_BWAY:  pend_q.bway_len       <= wr_data;
                A_BURST: pend_q.burst_len      <= wr_data;
                A_CBP:   pend_q.cbp_len        <= wr_data;
                A_XBP:   pend_q.xbp_len[7:0]   <= wr_data;
                A_ACT:   pend_q.act_len[7:0]   <= wr_data;
                A_FIRST: pend_q.first_len[7:0] <= wr_data;
                A_LAST:  pend_q.last_len[7:0]  <= wr_data;
                A_MSB: begin
                    pend_q.xbp_len[9:8]   <= wr_data[1:0];
                    pend_q.act_len[9:8]   <= wr_data[3:2];
                    pend_q.first_len[9:8] <= wr_data[5:4];
                    pend_q.last_len[9:8]  <= wr_data[7:6];
                end
                A_TOTL:  pend_q.total[7:0]     <= wr_data;
                A_TOTH:  pend_q.total[10:8]    <= wr_data[2:0];
                A_MODE: begin
                    pend_q.lines625 <= wr_data[0];
                    pend_q.pal      <= wr_data[1];
                    pend_q.setup    <= wr_data[2];
                end
                default: ;
            endcase
        end
    end

    // Move the pending set into the working set at the line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= CFG_RST;
        end else if (load) begin
            work_q <= pend_q;
        end
    end

    assign cfg = work_q;
endmodule

// File: rtl/vlt_line_count.sv
// Pixel position and line counters. The position runs 0..total-1
// (a total of 0 behaves as 1); `wrap` flags the last cycle of a line.
// The line counter wraps at the line count chosen by `lines625`.
module vlt_line_count
    import vlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOT_W-1:0]  total,
    input  logic              lines625,
    output logic [TOT_W-1:0]  pos,
    output logic [LINE_W-1:0] line,
    output logic              wrap
);
    localparam logic [LINE_W-1:0] LAST_A = LINE_W'(LINES_A - 1);
    localparam logic [LINE_W-1:0] LAST_B = LINE_W'(LINES_B - 1);

    logic [TOT_W-1:0]  last_pos;
    logic [LINE_W-1:0] last_line;

    // Last position and last line for the current configuration.
    always_comb begin
        last_pos  = (total == '0) ? '0 : total - 1'b1;
        last_line = lines625 ? LAST_B : LAST_A;
        wrap      = (pos >= last_pos);
    end

    // Advance the pixel position and the line number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            line <= '0;
        end else if (wrap) begin
            pos  <= '0;
            line <= (line >= last_line) ? '0 : line + 1'b1;
        end else begin
            pos  <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/vlt_seg_decode.sv
// Decodes the segment strobes from the pixel position and the working
// configuration. Segment end points are running sums of the lengths in
// line order: sync, breezeway, burst, colour back porch, extended back
// porch, active. Purely combinational.
module vlt_seg_decode
    import vlt_pkg::*;
(
    input  logic [TOT_W-1:0] pos,
    input  cfg_t             cfg,
    output logic             sync_o,
    output logic             burst_o,
    output logic             active_o,
    output logic             act_first_o,
    output logic             act_last_o
);
    logic [END_W-1:0] lens [NSEG];
    logic [END_W-1:0] ends [NSEG];
    logic [END_W-1:0] p;

    // Widen each segment length to the sum width, in line order.
    always_comb begin
        lens[0] = END_W'(cfg.sync_len);
        lens[1] = END_W'(cfg.bway_len);
        lens[2] = END_W'(cfg.burst_len);
        lens[3] = END_W'(cfg.cbp_len);
        lens[4] = END_W'(cfg.xbp_len);
        lens[5] = END_W'(cfg.act_len);
        p       = END_W'(pos);
    end

    // Running sums giving the end point of each segment.
    for (genvar i = 0; i < NSEG; i++) begin : g_end
        if (i == 0) begin : g_first
            assign ends[i] = lens[i];
        end else begin : g_rest
            assign ends[i] = ends[i-1] + lens[i];
        end
    end

    // Compare the position against the end points.
    always_comb begin
        sync_o      = (p < ends[0]);
        burst_o     = (p >= ends[1]) && (p < ends[2]);
        active_o    = (p >= ends[4]) && (p < ends[5]);
        act_first_o = active_o && (p < ends[4] + END_W'(cfg.first_len));
        act_last_o  = active_o && (p + END_W'(cfg.last_len) >= ends[5]);
    end
endmodule

// File: rtl/vlt_line_timer.sv
// Top level of the scan-line timing generator: register file, counters
// and segment decoder. Assumes the pixel clock is the only clock and
// the register port is driven synchronously to it.
module vlt_line_timer
    import vlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              sync_o,
    output logic              burst_o,
    output logic              blank_o,
    output logic              active_o,
    output logic              act_first_o,
    output logic              act_last_o,
    output logic              line_start_o,
    output logic              pedestal_o,
    output logic              pal_o,
    output logic [LINE_W-1:0] line_num_o
);
    cfg_t             cfg;
    logic [TOT_W-1:0] pos;
    logic             wrap;

    vlt_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (wrap),
        .cfg     (cfg)
    );

    vlt_line_count u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .total    (cfg.total),
        .lines625 (cfg.lines625),
        .pos      (pos),
        .line     (line_num_o),
        .wrap     (wrap)
    );

    vlt_seg_decode u_dec (
        .pos         (pos),
        .cfg         (cfg),
        .sync_o      (sync_o),
        .burst_o     (burst_o),
        .active_o    (active_o),
        .act_first_o (act_first_o),
        .act_last_o  (act_last_o)
    );

    // Line-level flags derived from position and mode.
    always_comb begin
        blank_o      = !active_o;
        line_start_o = (pos == '0);
        pedestal_o   = active_o && cfg.setup;
        pal_o        = cfg.pal;
    end
endmodule

// File: rtl/vlt_line_timer_chk.sv
// Property checker for the scan-line timing generator, bound to the top.
module vlt_line_timer_chk
    import vlt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sync_o,
    input logic              burst_o,
    input logic              active_o,
    input logic              act_first_o,
    input logic              act_last_o,
    input logic              line_start_o,
    input logic              pedestal_o,
    input logic [LINE_W-1:0] line_num_o
);
    p_seg_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_o, burst_o, active_o}));

    p_burst_no_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> !sync_o);

    p_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_o |-> $stable(line_num_o));

    p_line_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_o && line_num_o != '0) |-> (line_num_o == $past(line_num_o) + 1'b1));

    p_line_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_num_o < LINE_W'(LINES_B));

    p_halves_in_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_first_o || act_last_o) |-> active_o);

    p_pedestal_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pedestal_o |-> active_o);
endmodule

bind vlt_line_timer vlt_line_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_o       (sync_o),
    .burst_o      (burst_o),
    .active_o     (active_o),
    .act_first_o  (act_first_o),
    .act_last_o   (act_last_o),
    .line_start_o (line_start_o),
    .pedestal_o   (pedestal_o),
    .line_num_o   (line_num_o)
);

// File: tb/vlt_line_timer_bench.sv
// Bench: behavioural per-cycle model compared on every falling edge,
// plus directed checks on write timing, zero lengths, long lengths and
// line-count wrap.
module vlt_line_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sync_o, burst_o, blank_o, active_o, act_first_o, act_last_o;
    logic       line_start_o, pedestal_o, pal_o;
    logic [9:0] line_num_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // model state: 0..7 lengths, 8 total, 9 lines625, 10 pal, 11 setup
    int mp [12];
    int ma [12];
    int m_pos = 0;
    int m_line = 0;
    bit m_ok = 1'b0;

    always #4 clk = ~clk;

    vlt_line_timer u_vlt_line_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_o(sync_o), .burst_o(burst_o),
        .blank_o(blank_o), .active_o(active_o), .act_first_o(act_first_o),
        .act_last_o(act_last_o), .line_start_o(line_start_o),
        .pedestal_o(pedestal_o), .pal_o(pal_o), .line_num_o(line_num_o)
    );

    task automatic check(input string req, input int actv, input int expv);
        n_chk++;
        if (actv != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, actv, expv, cyc);
        end
    endtask

    function automatic void model_reset();
        int d [12] = '{4, 2, 4, 2, 0, 40, 20, 20, 64, 0, 0, 0};
        for (int k = 0; k < 12; k++) begin
            mp[k] = d[k];
            ma[k] = d[k];
        end
        m_pos = 0;
        m_line = 0;
    endfunction

    // Reference model update on the active edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            model_reset();
            m_ok = 1'b1;
        end else if (m_ok) begin
            int last;
            last = (ma[8] == 0) ? 0 : ma[8] - 1;
            if (m_pos >= last) begin
                m_pos = 0;
                m_line = (m_line >= (ma[9] != 0 ? 624 : 524)) ? 0 : m_line + 1;
                for (int k = 0; k < 12; k++) ma[k] = mp[k];
            end else begin
                m_pos++;
            end
            if (wr_en) begin
                case (int'(wr_addr))
                    0, 1, 2, 3: mp[wr_addr] = wr_data;
                    4, 5, 6, 7: mp[wr_addr] = (mp[wr_addr] & 768) | wr_data;
                    8: begin
                        mp[4] = (mp[4] & 255) | (int'(wr_data[1:0]) << 8);
                        mp[5] = (mp[5] & 255) | (int'(wr_data[3:2]) << 8);
                        mp[6] = (mp[6] & 255) | (int'(wr_data[5:4]) << 8);
                        mp[7] = (mp[7] & 255) | (int'(wr_data[7:6]) << 8);
                    end
                    9:  mp[8] = (mp[8] & 1792) | wr_data;
                    10: mp[8] = (mp[8] & 255) | (int'(wr_data[2:0]) << 8);
                    11: begin
                        mp[9]  = wr_data[0];
                        mp[10] = wr_data[1];
                        mp[11] = wr_data[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && m_ok) begin
            int e0, e1, e2, e4, e5;
            bit ea, ef, el;
            e0 = ma[0]; e1 = e0 + ma[1]; e2 = e1 + ma[2];
            e4 = e2 + ma[3] + ma[4]; e5 = e4 + ma[5];
            ea = (m_pos >= e4) && (m_pos < e5);
            ef = ea && (m_pos < e4 + ma[6]);
            el = ea && (m_pos + ma[7] >= e5);
            check("R1 sync", sync_o, m_pos < e0);
            check("R2 burst", burst_o, (m_pos >= e1) && (m_pos < e2));
            check("R3 active", active_o, ea);
            check("R3 blank", blank_o, !ea);
            check("R11 first", act_first_o, ef);
            check("R11 last", act_last_o, el);
            check("R6 line_start", line_start_o, m_pos == 0);
            check("R7 line", line_num_o, m_line);
            check("R9 pal", pal_o, ma[10]);
            check("R10 pedestal", pedestal_o, ea && ma[11] != 0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        wr_addr = 4'(a);
        wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!line_start_o) @(negedge clk);
    endtask

    initial begin
        int cnt, cnt2, guard;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: state one edge after reset release is position 1 of line 0
        check("R12 line after reset", line_num_o, 0);
        check("R12 sync running", sync_o, 1);
        repeat (200) @(negedge clk);

        // R8: a write during a line leaves that line unchanged
        wait_start();
        wr(0, 10);                       // now at position 1
        repeat (4) @(negedge clk);       // position 5
        check("R8 old sync kept", sync_o, 0);
        wait_start();
        repeat (5) @(negedge clk);
        check("R8 new sync applied", sync_o, 1);
        wr(0, 4);

        // R5, R9, R10: zero burst, PAL status and pedestal
        wr(2, 0);
        wr(11, 6);
        wait_start();
        wait_start();
        cnt = 0;
        cnt2 = 0;
        for (int k = 0; k < 64; k++) begin
            if (burst_o) cnt++;
            if (pedestal_o) cnt2++;
            @(negedge clk);
        end
        check("R5 zero burst cycles", cnt, 0);
        check("R10 pedestal cycles", cnt2, 40);
        check("R9 pal status", pal_o, 1);

        // R4, R6: long extended back porch from the top-bits register
        wr(2, 4);
        wr(4, 0);
        wr(8, 1);                        // extended back porch = 256
        wr(5, 100);
        wr(6, 30);
        wr(7, 30);
        wr(9, 8'hBC);
        wr(10, 2);                       // total = 700
        wr(11, 0);
        wait_start();
        wait_start();
        repeat (267) @(negedge clk);
        check("R4 active not yet", active_o, 0);
        @(negedge clk);
        check("R4 active at 268", active_o, 1);
        repeat (500) @(negedge clk);

        // R7: 525-line wrap on a 4-cycle line
        wr(0, 1); wr(1, 0); wr(2, 1); wr(3, 0);
        wr(8, 0); wr(4, 0); wr(5, 1); wr(6, 1); wr(7, 0);
        wr(9, 4); wr(10, 0);
        guard = 0;
        while (!(line_num_o == 10'd524 && line_start_o) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check("R7 reached line 524", line_num_o, 524);
        wait_start();
        check("R7 wrap after 524", line_num_o, 0);

        // R7: 625-line wrap
        wr(11, 1);
        guard = 0;
        while (!(line_num_o == 10'd624 && line_start_o) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check("R7 reached line 624", line_num_o, 624);
        wait_start();
        check("R7 wrap after 624", line_num_o, 0);

        // R6: total of zero behaves as a one-cycle line
        wr(9, 0);
        wait_start();
        wait_start();
        @(negedge clk);
        check("R6 one-cycle line start", line_start_o, 1);
        repeat (20) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule